// File: doc/BRIEF.md
# Streaming Binary Phase Packer

This block turns a raster stream of interference intensities from a camera into a packed binary phase map for a mirror-array display. Before operation, one frame is captured with the sample beam blocked and held per pixel as the reference intensity. After that, each arriving pixel is compared with its own stored reference as soon as it arrives. A brighter pixel means the phase difference lies within a quarter turn, and that pixel's mirror is switched on. A pixel that is not brighter is switched off.

The resulting bits are gathered 24 at a time into one word, which is sent as a single 24-bit RGB pixel on the display link. The decision and the packing run inline with the camera transfer. The last word of a frame therefore leaves one cycle after the last camera pixel is accepted. Frame width and height are parameters. The defaults are small so that the reference store stays light in simulation, and the width must be a multiple of 24.

Top module: `phase_pack_top`

## Requirements
- R1: After reset, `word_valid` and `word_sof` are low until a packed word is produced.
- R2: While `load_ref` is high, each accepted pixel is written into the reference store at its raster position, and no packed word is produced for it.
- R3: In compare mode, a pixel gives phase bit 1 when its intensity is strictly greater than its stored reference. It gives 0 when the intensity is equal to or lower than the reference.
- R4: Within a word, bit k holds the k-th pixel of its group of 24, counted from the left. Bit 0 is the leftmost pixel, and bits 23:16, 15:8 and 7:0 form the R, G and B bytes.
- R5: In the default configuration, a word is valid in the cycle right after the clock edge that accepts the 24th pixel of its group, and `word_valid` is low in every other cycle.
- R6: The first word of each frame carries `word_sof` high. A complete frame yields exactly width*height/24 valid words.
- R7: Idle cycles (`pix_valid` low) between pixels do not change any decision, word content or word count.
- R8: A frame start received mid-frame restores raster position 0 and drops any partly filled group. The next frame is then packed from its first pixel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| load_ref | input | 1 | High: accepted pixels fill the reference store |
| pix_valid | input | 1 | Camera pixel present this cycle |
| pix_sof | input | 1 | Pixel is the first of a frame |
| pix_sol | input | 1 | Pixel is the first of a line |
| pix_data | input | PIX_W | Camera intensity |
| word_valid | output | 1 | Packed word present |
| word_sof | output | 1 | Word is the first of a frame |
| word_data | output | 24 | Packed phase bits, bit 0 = leftmost pixel |

## Verification
The assertions rely on three properties of the input stream. Every frame opens with `pix_sof`. A frame never has more than width*height pixels before the next frame start. `pix_sol` arrives only at raster positions that are a multiple of the width. The bench's stimulus generator follows these rules: it raises `pix_sol` only on the first pixel of each line, places idle gaps only between pixels, and ends its single short frame with a fresh `pix_sof` instead of overrunning. Intensities are drawn at random, biased towards values that equal the stored reference or differ from it by one.

// File: rtl/phase_pack_pkg.sv
package phase_pack_pkg;
   localparam int unsigned PACK_BITS = 24;
   localparam int unsigned CNT_W     = $clog2(PACK_BITS);
   typedef logic [PACK_BITS-1:0] pack_word_t;
endpackage

// File: rtl/pp_raster_index.sv
module pp_raster_index #(
   parameter int unsigned WIDTH  = 48,
   parameter int unsigned HEIGHT = 4,
   localparam int unsigned PIXELS = WIDTH * HEIGHT,
   localparam int unsigned IDX_W  = $clog2(PIXELS + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pix_valid,
   input  logic             pix_sof,
   input  logic             pix_sol,
   output logic [IDX_W-1:0] addr
);
   logic [IDX_W-1:0] next_idx;

   assign addr = pix_sof ? '0 : next_idx;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         next_idx <= '0;
      else if (pix_valid) next_idx <= addr + 1'b1;
   end

   AST_PIXEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      pix_valid |-> (addr < IDX_W'(PIXELS))); // R8
   AST_LINE_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
      (pix_valid && pix_sol) |-> ((addr % IDX_W'(WIDTH)) == '0)); // R7
endmodule

// File: rtl/pp_ref_cmp.sv
module pp_ref_cmp #(
   parameter int unsigned PIX_W   = 10,
   parameter int unsigned PIXELS  = 192,
   parameter bit          REG_OUT = 1'b0,
   localparam int unsigned AW     = $clog2(PIXELS),
   localparam int unsigned IDX_W  = $clog2(PIXELS + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic             cmp_en,
   input  logic             cmp_sof,
   input  logic [IDX_W-1:0] addr,
   input  logic [PIX_W-1:0] pix_data,
   output logic             bit_valid,
   output logic             bit_sof,
   output logic             bit_out
);
   logic [PIX_W-1:0] ref_mem [PIXELS];
   logic             decision;

   always_ff @(posedge clk) begin
      if (wr_en) ref_mem[addr[AW-1:0]] <= pix_data;
   end

   assign decision = pix_data > ref_mem[addr[AW-1:0]];

   generate
      if (REG_OUT) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               bit_valid <= 1'b0;
               bit_sof   <= 1'b0;
               bit_out   <= 1'b0;
            end else begin
               bit_valid <= cmp_en;
               bit_sof   <= cmp_en & cmp_sof;
               bit_out   <= decision;
            end
         end
      end else begin : g_comb
         assign bit_valid = cmp_en;
         assign bit_sof   = cmp_en & cmp_sof;
         assign bit_out   = decision;
      end
   endgenerate

   AST_MODE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && cmp_en)); // R2
endmodule

// File: rtl/pp_packer.sv
module pp_packer
   import phase_pack_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       bit_valid,
   input  logic       bit_sof,
   input  logic       bit_in,
   output logic       word_valid,
   output logic       word_sof,
   output pack_word_t word_data
);
   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] slot;
   logic             first;
   logic             first_eff;
   pack_word_t       acc;

   assign slot      = bit_sof ? '0 : cnt;
   assign first_eff = bit_sof | first;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt        <= '0;
         first      <= 1'b0;
         acc        <= '0;
         word_valid <= 1'b0;
         word_sof   <= 1'b0;
         word_data  <= '0;
      end else begin
         word_valid <= 1'b0;
         word_sof   <= 1'b0;
         if (bit_valid) begin
            if (slot == CNT_W'(PACK_BITS - 1)) begin
               word_data  <= {bit_in, acc[PACK_BITS-2:0]};
               word_valid <= 1'b1;
               word_sof   <= first_eff;
               cnt        <= '0;
               first      <= 1'b0;
            end else begin
               acc[slot]  <= bit_in;
               cnt        <= slot + 1'b1;
               first      <= first_eff;
            end
         end
      end
   end

   AST_WORD_FOLLOWS_BIT: assert property (@(posedge clk) disable iff (!rst_n)
      word_valid |-> $past(bit_valid)); // R5
   AST_SOF_IN_WORD: assert property (@(posedge clk) disable iff (!rst_n)
      word_sof |-> word_valid); // R6
endmodule

// File: rtl/phase_pack_top.sv
module phase_pack_top #(
   parameter int unsigned WIDTH   = 48,
   parameter int unsigned HEIGHT  = 4,
   parameter int unsigned PIX_W   = 10,
   parameter bit          REG_OUT = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_ref,
   input  logic             pix_valid,
   input  logic             pix_sof,
   input  logic             pix_sol,
   input  logic [PIX_W-1:0] pix_data,
   output logic             word_valid,
   output logic             word_sof,
   output logic [23:0]      word_data
);
   import phase_pack_pkg::*;

   localparam int unsigned PIXELS      = WIDTH * HEIGHT;
   localparam int unsigned IDX_W       = $clog2(PIXELS + 1);
   localparam int unsigned FRAME_WORDS = PIXELS / PACK_BITS;
   localparam int unsigned WC_W        = $clog2(FRAME_WORDS + 1);

   generate
      if ((WIDTH % PACK_BITS) != 0) begin : g_bad_width
         $error("WIDTH must be a multiple of the packed word width");
      end
      if (HEIGHT < 1 || PIX_W < 1) begin : g_bad_dims
         $error("HEIGHT and PIX_W must be at least 1");
      end
   endgenerate

   logic [IDX_W-1:0] addr;
   logic             bit_valid, bit_sof, bit_val;
   pack_word_t       packed_word;

   pp_raster_index #(.WIDTH(WIDTH), .HEIGHT(HEIGHT)) u_index (
      .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid),
      .pix_sof(pix_sof), .pix_sol(pix_sol), .addr(addr)
   );

   pp_ref_cmp #(.PIX_W(PIX_W), .PIXELS(PIXELS), .REG_OUT(REG_OUT)) u_cmp (
      .clk(clk), .rst_n(rst_n),
      .wr_en(pix_valid & load_ref), .cmp_en(pix_valid & ~load_ref),
      .cmp_sof(pix_sof), .addr(addr), .pix_data(pix_data),
      .bit_valid(bit_valid), .bit_sof(bit_sof), .bit_out(bit_val)
   );

   pp_packer u_pack (
      .clk(clk), .rst_n(rst_n), .bit_valid(bit_valid), .bit_sof(bit_sof),
      .bit_in(bit_val), .word_valid(word_valid), .word_sof(word_sof),
      .word_data(packed_word)
   );

   assign word_data = packed_word;

   logic [WC_W-1:0] words_in_frame;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          words_in_frame <= '0;
      else if (word_valid) words_in_frame <= word_sof ? WC_W'(1) : words_in_frame + 1'b1;
   end

   AST_FRAME_WORDS: assert property (@(posedge clk) disable iff (!rst_n)
      (word_valid && !word_sof) |-> (words_in_frame < WC_W'(FRAME_WORDS))); // R6

   generate
      if (!REG_OUT) begin : g_load_chk
         AST_LOAD_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
            (pix_valid && load_ref) |=> !word_valid); // R2
      end
   endgenerate
endmodule

// File: tb/phase_pack_top_tb.sv
`timescale 1ns/1ps
module phase_pack_top_tb;
   localparam int unsigned W      = 48;
   localparam int unsigned H      = 4;
   localparam int unsigned IW     = 10;
   localparam int unsigned PIXELS = W * H;
   localparam int unsigned FW     = PIXELS / 24;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic load_ref = 1'b0, pix_valid = 1'b0, pix_sof = 1'b0, pix_sol = 1'b0;
   logic [IW-1:0] pix_data = '0;
   logic word_valid, word_sof;
   logic [23:0] word_data;

   int checks = 0;
   int errors = 0;

   always #2.5 clk = ~clk;

   phase_pack_top #(.WIDTH(W), .HEIGHT(H), .PIX_W(IW)) u_dut (
      .clk(clk), .rst_n(rst_n), .load_ref(load_ref), .pix_valid(pix_valid),
      .pix_sof(pix_sof), .pix_sol(pix_sol), .pix_data(pix_data),
      .word_valid(word_valid), .word_sof(word_sof), .word_data(word_data)
   );

   logic [IW-1:0] ref_m [PIXELS];
   int            pos = 0, gcnt = 0;
   logic          gfirst = 1'b0;
   logic [23:0]   gbits = '0;
   logic          exp_v = 1'b0, exp_s = 1'b0;
   logic [23:0]   exp_w = '0;
   int            frame_words = 0;
   bit            directed = 1'b0;
   string         tag = "R5";

   function automatic logic phase_bit(input logic [IW-1:0] d, input logic [IW-1:0] r);
      return d > r;  // R3: strictly greater gives 1
   endfunction

   task automatic step(input logic v, input logic s, input logic l,
                       input logic ld, input logic [IW-1:0] d);
      @(negedge clk);
      checks++;
      if (word_valid !== exp_v || (exp_v && (word_data !== exp_w || word_sof !== exp_s))) begin
         errors++;
         $display("FAIL %s: valid=%b sof=%b data=%h expected valid=%b sof=%b data=%h",
                  tag, word_valid, word_sof, word_data, exp_v, exp_s, exp_w);
      end
      if (word_valid) frame_words++;
      if (directed && word_valid) begin
         checks++;  // R4 bit order: pixel 0 -> bit 0, pixel 23 -> bit 23 (R byte msb)
         if (word_data !== 24'h800001) begin
            errors++;
            $display("FAIL R4: data=%h expected=%h", word_data, 24'h800001);
         end
      end
      pix_valid = v; pix_sof = s; pix_sol = l; load_ref = ld; pix_data = d;
      exp_v = 1'b0; exp_s = 1'b0;
      if (v) begin
         if (s) pos = 0;
         if (ld) begin
            ref_m[pos] = d;
         end else begin
            if (s) begin gcnt = 0; gfirst = 1'b1; end
            gbits[gcnt] = phase_bit(d, ref_m[pos]);
            gcnt++;
            if (gcnt == 24) begin
               exp_v = 1'b1; exp_w = gbits; exp_s = gfirst;
               gfirst = 1'b0; gcnt = 0;
            end
         end
         pos++;
      end
   endtask

   task automatic idle();
      step(1'b0, 1'b0, 1'b0, load_ref, IW'($urandom));
   endtask

   // mode: 0 load random, 1 compare random, 2 compare directed
   task automatic run_frame(input int mode, input int npix, input int stall_pct);
      for (int p = 0; p < npix; p++) begin
         logic [IW-1:0] d;
         int r;
         if (stall_pct > 0 && ($urandom % 100) < stall_pct) begin
            for (int k = 0; k < 1 + int'($urandom % 3); k++) idle();
         end
         r = int'($urandom % 4);
         if (mode == 0) d = IW'($urandom % ((1 << IW) - 1));
         else if (mode == 2) d = ((p % 24 == 0) || (p % 24 == 23)) ? ref_m[p] + 1'b1 : ref_m[p];
         else if (r == 0) d = ref_m[p];
         else if (r == 1) d = ref_m[p] + 1'b1;
         else if (r == 2) d = (ref_m[p] == '0) ? '0 : ref_m[p] - 1'b1;
         else d = IW'($urandom);
         step(1'b1, p == 0, (p % W) == 0, mode == 0, d);
      end
      step(1'b0, 1'b0, 1'b0, mode == 0, '0);
   endtask

   task automatic check_count(input string t, input int expv);
      checks++;
      if (frame_words != expv) begin
         errors++;
         $display("FAIL %s: frame words=%0d expected=%0d", t, frame_words, expv);
      end
   endtask

   initial begin
      #1_000_000;
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'd1957));
      for (int i = 0; i < PIXELS; i++) ref_m[i] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      checks++;  // R1
      if (word_valid !== 1'b0 || word_sof !== 1'b0) begin
         errors++;
         $display("FAIL R1: valid=%b sof=%b expected 0 0", word_valid, word_sof);
      end

      tag = "R2"; frame_words = 0;
      run_frame(0, PIXELS, 20);
      check_count("R2", 0);

      tag = "R3"; frame_words = 0;
      run_frame(1, PIXELS, 0);
      check_count("R6", FW);

      tag = "R7"; frame_words = 0;
      run_frame(1, PIXELS, 35);
      check_count("R7", FW);

      tag = "R4"; directed = 1'b1; frame_words = 0;
      run_frame(2, PIXELS, 10);
      directed = 1'b0;
      check_count("R4", FW);

      tag = "R8";
      run_frame(1, 30, 0);
      frame_words = 0;
      run_frame(1, PIXELS, 15);
      check_count("R8", FW);

      tag = "R2"; frame_words = 0;
      run_frame(0, PIXELS, 0);
      check_count("R2", 0);
      tag = "R5"; frame_words = 0;
      run_frame(1, PIXELS, 25);
      check_count("R6", FW);

      repeat (2) idle();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule